// File: doc/BRIEF.md
# DMA Staging Byte FIFO with Threshold Request

This block is a small byte queue placed between a network serial engine and a local DMA channel that moves packet data to or from buffer memory. In receive direction the network side deposits one byte per cycle and the DMA side removes data. In transmit direction the DMA side deposits data and the network side removes one byte per cycle. The DMA side moves single bytes or 16-bit words, low byte first.

A DMA request is raised when enough data is present (receive) or enough room is free (transmit). The trip point is set by a two-bit threshold select. The network side can never be stalled. Because of that, a late DMA grant shows up as a sticky overrun (receive) or underrun (transmit) error. An end-of-packet strobe in receive direction forces the request so that a short tail left below the threshold still gets drained.

The DMA data ports use valid/ready. A transfer happens in any cycle where both are high. The source must hold its data while valid is high and ready is low. The network ports have no back-pressure: a strobe is acted on in the cycle it is high. The direction, width and threshold pins should only change while the queue is empty.

Top module: `dma_stage_fifo`

## Requirements
- R1: The queue holds 16 bytes and returns them in the order written. In transmit direction `net_out_data` shows the oldest byte, or 0 when the queue is empty.
- R2: Threshold select value 0, 1, 2 or 3 sets a trip point of 2, 4, 8 or 12 bytes. In receive direction `dma_req` is high exactly while the byte count is at or above the trip point, unless R6 applies.
- R3: In transmit direction `dma_req` is high exactly while the free space (16 minus count) is at or above the trip point.
- R4: In byte mode (`word_mode`=0) each DMA handshake moves one byte on bits [7:0]. In receive direction bits [15:8] read 0.
- R5: In word mode each DMA handshake moves two bytes: bits [7:0] carry the older byte and bits [15:8] the newer. In receive direction `dma_out_valid` needs at least two bytes stored. In transmit direction `dma_in_ready` needs at least two bytes free.
- R6: After `eop` in receive direction, `dma_req` stays high while any byte remains, until the queue has emptied. A single leftover byte in word mode is then offered as one word with bits [15:8] = 0, and the handshake removes one byte.
- R7: A receive write while the queue holds 16 bytes sets `overrun`, and the byte is lost. While `overrun` is set, every later receive write is discarded.
- R8: A transmit read (`net_out_take`) while the queue is empty sets `underrun`. The flag stays set.
- R9: `err_clr` clears both flags. A new error in the same cycle wins over the clear.
- R10: `net_in_valid` has no effect in transmit direction, and `net_out_take` has no effect in receive direction.
- R11: After reset the queue is empty, both flags are low, and no end-of-packet drain is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xmit | input | 1 | 1 = transmit direction, 0 = receive |
| word_mode | input | 1 | 1 = 16-bit DMA transfers, 0 = bytes |
| thr_sel | input | 2 | Threshold select (2/4/8/12 bytes) |
| eop | input | 1 | Receive end-of-packet strobe |
| err_clr | input | 1 | Clears overrun and underrun |
| net_in_valid | input | 1 | Receive byte strobe from network |
| net_in_data | input | 8 | Receive byte |
| net_out_take | input | 1 | Transmit byte taken by network |
| net_out_data | output | 8 | Oldest byte for transmit |
| dma_in_valid | input | 1 | DMA write data valid (transmit) |
| dma_in_ready | output | 1 | Queue can accept a DMA write |
| dma_in_data | input | 16 | DMA write data |
| dma_out_valid | output | 1 | DMA read data valid (receive) |
| dma_out_ready | input | 1 | DMA accepts read data |
| dma_out_data | output | 16 | DMA read data |
| dma_req | output | 1 | Burst request to the DMA channel |
| overrun | output | 1 | Sticky receive overrun |
| underrun | output | 1 | Sticky transmit underrun |

## Verification
Directed receive sequences fill the queue with the DMA stalled and step through every threshold. This separates an off-by-one trip point from a correct one, and byte order from word order. Odd-length packets closed by `eop` in word mode show whether the tail byte is drained with a zeroed upper half. Fills past 16 bytes, and transmit reads on an empty queue, followed by clears with and without a coinciding error, show whether the flags are sticky and what happens to dropped bytes. Long random runs in all four direction/width combinations mix stalls, bursts and strobes on the unused network port. These runs compare every output each cycle against a queue model.

// File: rtl/dma_stage_pkg.sv
package dma_stage_pkg;
  // trip point for a threshold select value, scaled from the depth
  function automatic int trip_bytes(input int depth, input logic [1:0] sel);
    case (sel)
      2'd0:    return depth / 8;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return (depth * 3) / 4;
    endcase
  endfunction
endpackage

// File: rtl/stage_store.sv
module stage_store #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    push_cnt,
  input  logic [15:0]   wdata,
  input  logic [1:0]    pop_cnt,
  output logic [7:0]    head0,
  output logic [7:0]    head1,
  output logic [LW-1:0] level
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [7:0]    head [2];

  always_ff @(posedge clk) begin
    if (push_cnt != 2'd0) mem[wp] <= wdata[7:0];
    if (push_cnt == 2'd2) mem[AW'(wp + AW'(1))] <= wdata[15:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      wp    <= AW'(wp + AW'(push_cnt));
      rp    <= AW'(rp + AW'(pop_cnt));
      level <= LW'(level + LW'(push_cnt) - LW'(pop_cnt));
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_tap
    assign head[k] = mem[AW'(rp + AW'(k))];
  end
  assign head0 = head[0];
  assign head1 = head[1];

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_cnt != 2'd0) |-> (32'(level) + 32'(push_cnt) <= DEPTH));
  assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_cnt != 2'd0) |-> (32'(pop_cnt) <= 32'(level)));
endmodule

// File: rtl/stage_req.sv
module stage_req #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          xmit,
  input  logic [1:0]    thr_sel,
  input  logic [LW-1:0] level,
  input  logic          flush,
  output logic          req
);
  import dma_stage_pkg::*;
  logic [LW-1:0] trip, room;

  always_comb begin
    trip = LW'(trip_bytes(DEPTH, thr_sel));
    room = LW'(DEPTH) - level;
    if (xmit) req = (room >= trip);
    else      req = (level >= trip) || (flush && level != '0);
  end
endmodule

// File: rtl/stage_flags.sv
module stage_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ovr,
  input  logic set_und,
  input  logic clr,
  output logic ovr,
  output logic und
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr <= 1'b0;
      und <= 1'b0;
    end else begin
      ovr <= set_ovr | (ovr & ~clr);
      und <= set_und | (und & ~clr);
    end
  end

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr) |=> ovr);
  assert_und_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (und && !clr) |=> und);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_ovr && !set_und) |=> (!ovr && !und));
endmodule

// File: rtl/dma_stage_fifo.sv
module dma_stage_fifo #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xmit,
  input  logic        word_mode,
  input  logic [1:0]  thr_sel,
  input  logic        eop,
  input  logic        err_clr,
  input  logic        net_in_valid,
  input  logic [7:0]  net_in_data,
  input  logic        net_out_take,
  output logic [7:0]  net_out_data,
  input  logic        dma_in_valid,
  output logic        dma_in_ready,
  input  logic [15:0] dma_in_data,
  output logic        dma_out_valid,
  input  logic        dma_out_ready,
  output logic [15:0] dma_out_data,
  output logic        dma_req,
  output logic        overrun,
  output logic        underrun
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [LW-1:0] level, room;
  logic [7:0]    head0, head1;
  logic [1:0]    push_cnt, pop_cnt;
  logic [15:0]   wdata;
  logic          flush_q, has_word, set_ovr, set_und;

  always_comb begin
    room          = FULL - level;
    has_word      = level >= LW'(2);
    dma_out_valid = !xmit && (word_mode ? (has_word || (flush_q && level == LW'(1)))
                                        : (level != '0));
    dma_out_data  = word_mode ? {(has_word ? head1 : 8'h00), head0} : {8'h00, head0};
    dma_in_ready  = xmit && (word_mode ? (room >= LW'(2)) : (level != FULL));
    net_out_data  = (xmit && level != '0) ? head0 : 8'h00;
    if (xmit) begin
      push_cnt = (dma_in_valid && dma_in_ready) ? (word_mode ? 2'd2 : 2'd1) : 2'd0;
      wdata    = dma_in_data;
      pop_cnt  = (net_out_take && level != '0) ? 2'd1 : 2'd0;
    end else begin
      push_cnt = (net_in_valid && level != FULL && !overrun) ? 2'd1 : 2'd0;
      wdata    = {8'h00, net_in_data};
      pop_cnt  = (dma_out_valid && dma_out_ready) ? ((word_mode && has_word) ? 2'd2 : 2'd1)
                                                  : 2'd0;
    end
    set_ovr = !xmit && net_in_valid && level == FULL;
    set_und = xmit && net_out_take && level == '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                           flush_q <= 1'b0;
    else if (!xmit && eop)                                flush_q <= 1'b1;
    else if (flush_q && level == '0 && push_cnt == 2'd0)  flush_q <= 1'b0;
  end

  stage_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push_cnt(push_cnt), .wdata(wdata),
    .pop_cnt(pop_cnt), .head0(head0), .head1(head1), .level(level)
  );

  stage_req #(.DEPTH(DEPTH)) u_req (
    .xmit(xmit), .thr_sel(thr_sel), .level(level), .flush(flush_q), .req(dma_req)
  );

  stage_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_ovr(set_ovr), .set_und(set_und),
    .clr(err_clr), .ovr(overrun), .und(underrun)
  );

  assert_overrun_on_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!xmit && net_in_valid && level == FULL) |=> overrun);
  assert_drop_while_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!xmit && overrun && !(dma_out_valid && dma_out_ready)) |=> (level == $past(level)));
  assert_underrun_on_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit && net_out_take && level == '0) |=> underrun);
  assert_word_pairs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!xmit && word_mode && dma_out_valid && !flush_q) |-> (level >= LW'(2)));
endmodule

// File: tb/tb_dma_stage_fifo.sv
module tb_dma_stage_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xmit = 0, word_mode = 0, eop = 0, err_clr = 0;
  logic [1:0] thr_sel = 0;
  logic net_in_valid = 0, net_out_take = 0, dma_in_valid = 0, dma_out_ready = 0;
  logic [7:0] net_in_data = 0;
  logic [15:0] dma_in_data = 0;
  logic [7:0] net_out_data;
  logic dma_in_ready, dma_out_valid, dma_req, overrun, underrun;
  logic [15:0] dma_out_data;

  always #2.5 clk = ~clk;

  dma_stage_fifo dut (.*);

  int errs = 0, checks = 0, cycles = 0;
  bit done = 0;
  byte unsigned q[$];
  bit m_ovr, m_und, m_flush;
  bit e_req, e_ov, e_ir;
  logic [15:0] e_od;
  logic [7:0] e_nod;

  function automatic int trip(input logic [1:0] s);
    case (s) 2'd0: return 2; 2'd1: return 4; 2'd2: return 8; default: return 12; endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic expect_now();
    int n = q.size();
    int t = trip(thr_sel);
    e_req = 0; e_ov = 0; e_ir = 0; e_od = 0; e_nod = 0;
    if (!xmit) begin
      e_req = (n >= t) || (m_flush && n != 0);
      e_ov  = word_mode ? (n >= 2 || (m_flush && n == 1)) : (n != 0);
      if (n != 0) e_od = word_mode ? {(n >= 2 ? q[1] : 8'h00), q[0]} : {8'h00, q[0]};
    end else begin
      e_req = (16 - n) >= t;
      e_ir  = word_mode ? ((16 - n) >= 2) : (n < 16);
      if (n != 0) e_nod = q[0];
    end
  endtask

  task automatic compare();
    expect_now();
    check(xmit ? "R3" : (m_flush ? "R6" : "R2"), "dma_req", int'(dma_req), int'(e_req));
    check(word_mode ? "R5" : "R4", "dma_out_valid", int'(dma_out_valid), int'(e_ov));
    if (e_ov) check(word_mode ? "R5" : "R4", "dma_out_data", int'(dma_out_data), int'(e_od));
    check(word_mode ? "R5" : "R4", "dma_in_ready", int'(dma_in_ready), int'(e_ir));
    check(xmit ? "R1" : "R10", "net_out_data", int'(net_out_data), int'(e_nod));
    check(xmit ? "R10" : "R7", "overrun", int'(overrun), int'(m_ovr));
    check(xmit ? "R8" : "R10", "underrun", int'(underrun), int'(m_und));
  endtask

  task automatic model_update();
    int n = q.size();
    bit s_ov = 0, s_un = 0;
    expect_now();
    if (!xmit) begin
      int pops = (e_ov && dma_out_ready) ? ((word_mode && n >= 2) ? 2 : 1) : 0;
      bit pushed = net_in_valid && n < 16 && !m_ovr;
      s_ov = net_in_valid && n == 16;
      if (eop) m_flush = 1;
      else if (m_flush && n == 0 && !pushed) m_flush = 0;
      repeat (pops) void'(q.pop_front());
      if (pushed) q.push_back(net_in_data);
    end else begin
      if (dma_in_valid && e_ir) begin
        q.push_back(dma_in_data[7:0]);
        if (word_mode) q.push_back(dma_in_data[15:8]);
      end
      if (net_out_take) begin
        if (n != 0) void'(q.pop_front());
        else s_un = 1;
      end
    end
    if (err_clr) begin m_ovr = 0; m_und = 0; end
    if (s_ov) m_ovr = 1;
    if (s_un) m_und = 1;
  endtask

  // inputs are driven after a falling edge; compare, then advance one clock
  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_update();
    cycles++;
    @(negedge clk);
  endtask

  task automatic idle();
    eop = 0; err_clr = 0; net_in_valid = 0; net_out_take = 0;
    dma_in_valid = 0; dma_out_ready = 0;
  endtask

  task automatic restart(input bit tx, input bit wm, input logic [1:0] ts);
    @(negedge clk);
    idle();
    rst_n = 0; xmit = tx; word_mode = wm; thr_sel = ts;
    q.delete(); m_ovr = 0; m_und = 0; m_flush = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    // R11: reset state
    check("R11", "underrun after reset", int'(underrun), 0);
    check("R11", "overrun after reset", int'(overrun), 0);
    check("R11", "dma_out_valid after reset", int'(dma_out_valid), 0);
    if (!tx) check("R11", "dma_req after reset", int'(dma_req), 0);
  endtask

  task automatic rx_byte(input logic [7:0] b);
    net_in_valid = 1; net_in_data = b; tick(); net_in_valid = 0;
  endtask

  initial begin
    // threshold sweep in receive byte mode (R2, R4)
    for (int ts = 0; ts < 4; ts++) begin
      restart(0, 0, 2'(ts));
      for (int i = 0; i < 14; i++) rx_byte(8'(8'h10 + i));
      dma_out_ready = 1;
      repeat (16) tick();
      idle();
    end

    // word mode ordering and odd tail drained by end of packet (R5, R6)
    restart(0, 1, 2'd2);
    for (int i = 0; i < 5; i++) rx_byte(8'(8'hA0 + i));
    eop = 1; tick(); eop = 0;
    check("R6", "dma_req after eop", int'(dma_req), 1);
    dma_out_ready = 1; tick(); tick();
    check("R6", "tail word", int'(dma_out_data), 16'h00A4);
    check("R6", "tail valid", int'(dma_out_valid), 1);
    tick();
    check("R6", "drained", int'(dma_out_valid), 0);
    check("R6", "req released", int'(dma_req), 0);
    idle(); tick();

    // overrun, dropped writes, clear (R7, R9)
    restart(0, 0, 2'd3);
    for (int i = 0; i < 18; i++) rx_byte(8'(i));
    check("R7", "overrun set", int'(overrun), 1);
    err_clr = 1; net_in_valid = 1; net_in_data = 8'hEE; tick(); idle();
    check("R9", "set wins over clear", int'(overrun), 1);
    err_clr = 1; tick(); idle();
    check("R9", "overrun cleared", int'(overrun), 0);
    dma_out_ready = 1; tick();
    check("R7", "oldest byte kept", int'(dma_out_data), 16'h0001);
    repeat (18) tick();
    idle();

    // transmit word writes, byte reads, underrun (R3, R5, R8, R10)
    restart(1, 1, 2'd1);
    for (int i = 0; i < 9; i++) begin
      dma_in_valid = 1; dma_in_data = 16'(16'h2100 + 16'h0202 * i + 16'h0100);
      net_in_valid = 1; net_in_data = 8'h55; tick();
    end
    idle();
    net_out_take = 1;
    repeat (17) tick();
    check("R8", "underrun set", int'(underrun), 1);
    idle(); err_clr = 1; tick(); idle();
    check("R9", "underrun cleared", int'(underrun), 0);

    // random traffic in every direction/width combination
    for (int cfg = 0; cfg < 4; cfg++) begin
      restart(cfg[1], cfg[0], 2'($urandom_range(0, 3)));
      for (int i = 0; i < 600; i++) begin
        net_in_valid  = ($urandom_range(0, 3) != 0);
        net_in_data   = 8'($urandom);
        net_out_take  = ($urandom_range(0, 2) == 0);
        dma_in_valid  = ($urandom_range(0, 1) == 0);
        dma_in_data   = 16'($urandom);
        dma_out_ready = ($urandom_range(0, 2) == 0);
        eop           = ($urandom_range(0, 40) == 0);
        err_clr       = ($urandom_range(0, 30) == 0);
        tick();
      end
      idle();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule